// File: doc/BRIEF.md
# Colour-to-Gray Converter with 6×6 Neighbourhood Generator

This block sits at the front of a pixel-stream feature pipeline. It accepts one RGB565 pixel per clock, along with a valid qualifier, a start-of-frame flag and an end-of-line flag. It reduces each pixel to an 8-bit intensity using adders and fixed shifts only. From that intensity stream it keeps a square neighbourhood of the most recent six rows by six columns.

Five row-long buffers hold the previous lines. Each buffer is a plain simple-dual-port array that maps onto on-chip block memory. A 6×6 register array shifts one new column in per accepted pixel.

Row and column counters follow the raster. They decide when the whole neighbourhood lies inside the current frame. They also report the coordinates of the neighbourhood's centre element, so a downstream scorer knows where each result belongs.

Top module: `rgb_gray_window`

## Requirements
- R1: The pixel fields are red = bits [15:11], green = bits [10:5] and blue = bits [4:0]. Red and blue widen to 8 bits by appending their three upper bits. Green widens to 8 bits by appending its two upper bits. The gray value is (2·G8 + R8 + B8) >> 2, truncated, so full white gives 255.
- R2: For a window completed by the pixel at row R, column C, the byte of `win_pix` at bit offset 8·(6·i + j) holds the gray value of row R−5+i, column C−5+j, for i and j from 0 to 5.
- R3: A window is emitted for a pixel only when R ≥ 5 and C ≥ 5. There is one window per such pixel, in arrival order. A complete frame therefore yields exactly (IMG_W−5)·(IMG_H−5) windows.
- R4: With each window, `win_row` = R−2 and `win_col` = C−2. This is element i = 3, j = 3 of the even-sized window.
- R5: The block accepts one pixel per clock with no backpressure. A pixel sampled with `in_valid` high at clock edge e produces its window just after edge e+2. Cycles with `in_valid` low shift nothing and emit nothing.
- R6: A valid pixel flagged with `in_sof` is row 0, column 0 of a new frame, even in the middle of a line. Line-buffer contents are not cleared. So after a truncated frame, the new frame emits nothing before its own row 5, column 5, and its windows hold only its own pixels.
- R7: A valid pixel flagged with `in_eol` ends its line: the next pixel is column 0 of the following row. A line without the flag ends in the same way after column IMG_W−1.
- R8: The asynchronous active-low reset clears `win_valid` and the raster counters. Its release is synchronised over two clock edges. After release, a stream without `in_sof` starts at row 0, column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Qualifies the input pixel in this cycle |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_eol | input | 1 | Pixel is the last of its line |
| in_rgb | input | 16 | RGB565 pixel |
| win_valid | output | 1 | Window, row and column outputs are valid |
| win_pix | output | WIN·WIN·8 (288) | Neighbourhood bytes, row-major from the oldest row and column |
| win_col | output | ceil(log2(IMG_W)) (10) | Column of the centre element |
| win_row | output | ceil(log2(IMG_H)) (9) | Row of the centre element |

## Verification
Two functions can fall in the same cycle: a new frame's start-of-frame pixel is accepted and resets the counters while the previous frame's last two windows are still in the pipeline. The bench provokes this by streaming one frame directly after another with no idle cycle, both after a frame whose lines have no end-of-line flag and after a frame cut short mid-line. It judges the result on three points. The trailing windows must keep the old frame's coordinates and pixels at the exact expected edge. The new frame must emit nothing until its own row 5, column 5. Its later windows must contain none of the stale line-buffer data.

// File: rtl/gwin_pkg.sv
`timescale 1ns/1ps
package gwin_pkg;
  localparam int PIX_W = 8;
  localparam int RGB_W = 16;

  typedef logic [PIX_W-1:0] gray_t;

  // widen a 5-bit channel by repeating its upper bits
  function automatic gray_t widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  // widen a 6-bit channel by repeating its upper bits
  function automatic gray_t widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction
endpackage

// File: rtl/gwin_luma.sv
`timescale 1ns/1ps
module gwin_luma
  import gwin_pkg::*;
(
  input  logic             clk,
  input  logic             in_en,
  input  logic [RGB_W-1:0] in_rgb,
  output gray_t            out_gray
);
  logic [PIX_W+1:0] wsum;
  gray_t            gray_d;

  // half green + quarter red + quarter blue, summed before the shift
  always_comb begin
    wsum   = {1'b0, widen6(in_rgb[10:5]), 1'b0}
           + {2'b00, widen5(in_rgb[15:11])}
           + {2'b00, widen5(in_rgb[4:0])};
    gray_d = wsum[PIX_W+1:2];
  end

  always_ff @(posedge clk) begin
    if (in_en) out_gray <= gray_d;
  end
endmodule

// File: rtl/gwin_raster.sv
`timescale 1ns/1ps
module gwin_raster #(
  parameter int IMG_W = 640,
  parameter int IMG_H = 480,
  localparam int COL_W = $clog2(IMG_W),
  localparam int ROW_W = $clog2(IMG_H)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eol,
  output logic             s1_valid,
  output logic [COL_W-1:0] s1_col,
  output logic [ROW_W-1:0] s1_row
);
  logic [COL_W-1:0] col_q, col_d, cur_col;
  logic [ROW_W-1:0] row_q, row_d, cur_row;
  logic             line_end;

  always_comb begin
    cur_col  = in_sof ? '0 : col_q;
    cur_row  = in_sof ? '0 : row_q;
    line_end = in_eol || (cur_col == COL_W'(IMG_W-1));
    col_d    = col_q;
    row_d    = row_q;
    if (in_valid) begin
      col_d = line_end ? '0 : cur_col + COL_W'(1);
      if (!line_end)                          row_d = cur_row;
      else if (cur_row == ROW_W'(IMG_H-1))    row_d = cur_row;
      else                                    row_d = cur_row + ROW_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q    <= '0;
      row_q    <= '0;
      s1_valid <= 1'b0;
    end else begin
      col_q    <= col_d;
      row_q    <= row_d;
      s1_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_col <= cur_col;
      s1_row <= cur_row;
    end
  end

  // R7: an end-of-line pixel returns the column to zero
  a_r7_eol_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eol) |=> (col_q == '0));

  // R7: an end-of-line pixel advances the row below the last one
  a_r7_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eol && !in_sof && (row_q != ROW_W'(IMG_H-1)))
      |=> (row_q == $past(row_q) + ROW_W'(1)));

  // R6: start-of-frame places the next pixel at row 0, column 1
  a_r6_sof_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && !in_eol) |=> (row_q == '0) && (col_q == COL_W'(1)));
endmodule

// File: rtl/gwin_linebank.sv
`timescale 1ns/1ps
module gwin_linebank
  import gwin_pkg::*;
#(
  parameter int DEPTH = 640,
  parameter int WIN   = 6,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic [AW-1:0]        rd_addr,
  input  gray_t                new_pix,
  output logic                 vec_valid,
  output logic [WIN*PIX_W-1:0] col_vec
);
  localparam int NBUF = WIN - 1;

  logic          wr_en;
  logic [AW-1:0] wr_addr;
  gray_t         new_q;
  gray_t         tap [NBUF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_en <= 1'b0;
    else        wr_en <= rd_en;
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      wr_addr <= rd_addr;
      new_q   <= new_pix;
    end
  end

  // each buffer: read at the new column, write one cycle later with the
  // value the buffer above it just delivered (row cascade)
  for (genvar k = 0; k < NBUF; k++) begin : g_buf
    gray_t mem [DEPTH];
    gray_t rd_q;
    gray_t wr_d;
    if (k == 0) begin : g_head
      assign wr_d = new_q;
    end else begin : g_tail
      assign wr_d = tap[k-1];
    end
    always_ff @(posedge clk) begin
      if (rd_en) rd_q <= mem[rd_addr];
      if (wr_en) mem[wr_addr] <= wr_d;
    end
    assign tap[k] = rd_q;
  end

  // column vector: element 0 is the oldest row, the last is the newest
  assign col_vec[(WIN-1)*PIX_W +: PIX_W] = new_q;
  for (genvar i = 0; i < NBUF; i++) begin : g_col
    assign col_vec[i*PIX_W +: PIX_W] = tap[NBUF-1-i];
  end
  assign vec_valid = wr_en;

  // R5: a read never targets the entry being written in the same cycle
  a_r5_no_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |-> (rd_addr != wr_addr));
endmodule

// File: rtl/gwin_array.sv
`timescale 1ns/1ps
module gwin_array
  import gwin_pkg::*;
#(
  parameter int WIN = 6
) (
  input  logic                     clk,
  input  logic                     shift_en,
  input  logic [WIN*PIX_W-1:0]     col_vec,
  output logic [WIN*WIN*PIX_W-1:0] win_flat
);
  gray_t cell_q [WIN][WIN];
  gray_t cell_d [WIN][WIN];

  always_comb begin
    for (int i = 0; i < WIN; i++) begin
      for (int j = 0; j < WIN - 1; j++) cell_d[i][j] = cell_q[i][j+1];
      cell_d[i][WIN-1] = col_vec[i*PIX_W +: PIX_W];
    end
  end

  always_ff @(posedge clk) begin
    if (shift_en) cell_q <= cell_d;
  end

  for (genvar i = 0; i < WIN; i++) begin : g_row
    for (genvar j = 0; j < WIN; j++) begin : g_cell
      assign win_flat[(i*WIN+j)*PIX_W +: PIX_W] = cell_q[i][j];
    end
  end
endmodule

// File: rtl/rgb_gray_window.sv
`timescale 1ns/1ps
module rgb_gray_window
  import gwin_pkg::*;
#(
  parameter int IMG_W = 640,
  parameter int IMG_H = 480,
  parameter int WIN   = 6,
  localparam int COL_W = $clog2(IMG_W),
  localparam int ROW_W = $clog2(IMG_H)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_sof,
  input  logic                     in_eol,
  input  logic [RGB_W-1:0]         in_rgb,
  output logic                     win_valid,
  output logic [WIN*WIN*PIX_W-1:0] win_pix,
  output logic [COL_W-1:0]         win_col,
  output logic [ROW_W-1:0]         win_row
);
  // distance from the newest pixel back to the reported centre
  localparam int CTR_BACK = WIN - 1 - WIN / 2;

  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta} <= 2'b00;
    else        {rst_sync_n, rst_meta} <= {rst_meta, 1'b1};
  end

  logic                 s1_valid;
  logic [COL_W-1:0]     s1_col;
  logic [ROW_W-1:0]     s1_row;
  gray_t                s1_gray;
  logic                 vec_valid;
  logic [WIN*PIX_W-1:0] col_vec;
  logic [COL_W-1:0]     s2_col;
  logic [ROW_W-1:0]     s2_row;
  logic                 valid_d;

  gwin_luma u_luma (
    .clk      (clk),
    .in_en    (in_valid),
    .in_rgb   (in_rgb),
    .out_gray (s1_gray)
  );

  gwin_raster #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_raster (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .in_eol   (in_eol),
    .s1_valid (s1_valid),
    .s1_col   (s1_col),
    .s1_row   (s1_row)
  );

  gwin_linebank #(.DEPTH(IMG_W), .WIN(WIN)) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_en     (s1_valid),
    .rd_addr   (s1_col),
    .new_pix   (s1_gray),
    .vec_valid (vec_valid),
    .col_vec   (col_vec)
  );

  gwin_array #(.WIN(WIN)) u_array (
    .clk      (clk),
    .shift_en (vec_valid),
    .col_vec  (col_vec),
    .win_flat (win_pix)
  );

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      s2_col <= s1_col;
      s2_row <= s1_row;
    end
  end

  always_comb begin
    valid_d = vec_valid && (s2_row >= ROW_W'(WIN-1)) && (s2_col >= COL_W'(WIN-1));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) win_valid <= 1'b0;
    else             win_valid <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (vec_valid) begin
      win_col <= s2_col - COL_W'(CTR_BACK);
      win_row <= s2_row - ROW_W'(CTR_BACK);
    end
  end

  // R3: a reported centre never lies closer to the frame edge than the window allows
  a_r3_border: assert property (@(posedge clk) disable iff (!rst_sync_n)
    win_valid |-> (win_row >= ROW_W'(WIN-1-CTR_BACK)) && (win_col >= COL_W'(WIN-1-CTR_BACK)));

  // R4: back-to-back windows on one row step the centre by one column
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (win_valid && $past(win_valid) && (win_row == $past(win_row)))
      |-> (win_col == $past(win_col) + COL_W'(1)));

  // R5: every window is preceded by a column delivered from the line buffers
  a_r5_pipe: assert property (@(posedge clk) disable iff (!rst_sync_n)
    win_valid |-> $past(vec_valid));
endmodule

// File: tb/rgb_gray_window_test.sv
`timescale 1ns/1ps
module rgb_gray_window_test;
  localparam int W  = 10;
  localparam int H  = 8;
  localparam int WN = 6;
  localparam int CW = $clog2(W);
  localparam int RW = $clog2(H);
  localparam int NWIN = (W - 5) * (H - 5);

  // stimulus colour and the gray value R1 gives for it
  localparam logic [23:0] VEC [8] = '{
    {16'hFFFF, 8'hFF}, {16'h0000, 8'h00}, {16'hF800, 8'h3F}, {16'h07E0, 8'h7F},
    {16'h001F, 8'h3F}, {16'h8410, 8'h83}, {16'h1234, 8'h4F}, {16'hA5F3, 8'hAF}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_sof, in_eol;
  logic [15:0] in_rgb;
  logic win_valid;
  logic [WN*WN*8-1:0] win_pix;
  logic [CW-1:0] win_col;
  logic [RW-1:0] win_row;

  always #4 clk = ~clk;

  rgb_gray_window #(.IMG_W(W), .IMG_H(H), .WIN(WN)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
    .in_rgb(in_rgb), .win_valid(win_valid), .win_pix(win_pix),
    .win_col(win_col), .win_row(win_row)
  );

  int checks = 0;
  int fails = 0;
  int edge_cnt = 0;
  int n_acc = 0;
  int p = 0;
  int a_edge [600];
  int a_row [600];
  int a_col [600];
  int a_frm [600];
  int wins [6];
  logic [7:0] img [6][H][W];
  int mf, mr, mc;
  logic [WN*WN*8-1:0] mexp;
  bit finished = 0;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // monitor: compare each window with the oldest pending qualifying pixel
  always @(negedge clk) begin
    if (rst_n && win_valid) begin
      while (p < n_acc && !(a_row[p] >= 5 && a_col[p] >= 5)) p++;
      if (p >= n_acc) begin
        check(1'b0, "R3", $sformatf("window at row %0d col %0d, expected none", win_row, win_col));
      end else begin
        mf = a_frm[p]; mr = a_row[p]; mc = a_col[p];
        for (int i = 0; i < 6; i++)
          for (int j = 0; j < 6; j++)
            mexp[(i*6+j)*8 +: 8] = img[mf][mr-5+i][mc-5+j];
        check(edge_cnt == a_edge[p] + 2, "R5",
              $sformatf("window edge act %0d exp %0d", edge_cnt, a_edge[p] + 2));
        check(int'(win_row) == mr - 2 && int'(win_col) == mc - 2, "R4",
              $sformatf("centre act (%0d,%0d) exp (%0d,%0d)", win_row, win_col, mr - 2, mc - 2));
        check(win_pix == mexp, "R2 (R1 gray)",
              $sformatf("pixels act %h exp %h", win_pix, mexp));
        wins[mf]++;
        p++;
      end
    end
  end

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // walks the colour table over a frame of npix pixels
  task automatic send_frame(input int f, input int npix, input bit use_sof,
                            input bit use_eol, input bit gaps);
    for (int i = 0; i < npix; i++) begin
      int r = i / W;
      int c = i % W;
      int k = (r * 3 + c + f) % 8;
      if (gaps && (i % 3 == 2)) begin
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = use_sof && (i == 0);
      in_eol   = use_eol && (c == W - 1);
      in_rgb   = VEC[k][23:8];
      img[f][r][c] = VEC[k][7:0];
      a_edge[n_acc] = edge_cnt + 1;
      a_row[n_acc]  = r;
      a_col[n_acc]  = c;
      a_frm[n_acc]  = f;
      n_acc++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < 6; f++) wins[f] = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0; in_rgb = '0;
    repeat (3) @(negedge clk);
    check(win_valid == 1'b0, "R8", $sformatf("valid in reset act %0b exp 0", win_valid));
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(win_valid == 1'b0, "R8", $sformatf("valid after release act %0b exp 0", win_valid));

    // frame 0: full, flagged line ends, no gaps
    send_frame(0, W * H, 1'b1, 1'b1, 1'b0);
    idle(6);
    check(wins[0] == NWIN, "R3", $sformatf("frame 0 windows act %0d exp %0d", wins[0], NWIN));

    // frame 1 cut short mid-line, frame 2 starts at once without line flags and with gaps,
    // frame 3 follows frame 2 with no idle cycle
    send_frame(1, 3 * W + 4, 1'b1, 1'b1, 1'b0);
    send_frame(2, W * H, 1'b1, 1'b0, 1'b1);
    send_frame(3, W * H, 1'b1, 1'b1, 1'b0);
    idle(6);
    check(wins[1] == 0, "R6", $sformatf("truncated frame windows act %0d exp 0", wins[1]));
    check(wins[2] == NWIN, "R7", $sformatf("unflagged frame windows act %0d exp %0d", wins[2], NWIN));
    check(wins[3] == NWIN, "R6", $sformatf("back-to-back frame windows act %0d exp %0d", wins[3], NWIN));

    // frame 4 interrupted by reset, frame 5 sent without start-of-frame
    send_frame(4, 2 * W + 3, 1'b1, 1'b1, 1'b0);
    idle(4);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(win_valid == 1'b0, "R8", $sformatf("valid in mid-run reset act %0b exp 0", win_valid));
    rst_n = 1'b1;
    p = n_acc;
    idle(5);
    send_frame(5, W * H, 1'b0, 1'b1, 1'b0);
    idle(6);
    check(wins[4] == 0, "R3", $sformatf("short frame windows act %0d exp 0", wins[4]));
    check(wins[5] == NWIN, "R8", $sformatf("post-reset frame windows act %0d exp %0d", wins[5], NWIN));
    check(win_valid == 1'b0, "R5", $sformatf("valid while idle act %0b exp 0", win_valid));

    while (p < n_acc && !(a_row[p] >= 5 && a_col[p] >= 5)) p++;
    check(p == n_acc, "R3", $sformatf("windows outstanding act %0d exp 0", n_acc - p));

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule